// File: doc/BRIEF.md
# Capsule vector squash unit

This block applies the capsule squashing nonlinearity to one vector of `D` signed fixed-point elements. Each element is a two's-complement integer whose real value is the integer scaled by 2^-16. A one-cycle `start` pulse captures the whole vector from `vec_in` in parallel. The unit then works through a fixed sequence. It sums the squares of the elements into a wide accumulator. It extracts the integer square root of that sum, one result bit per cycle, to get the magnitude. It divides the magnitude by one plus the squared norm, one quotient bit per cycle. Finally it multiplies each stored element by that common factor, one element per cycle.

The scale applied to every element is |s|/(1+|s|^2). This equals |s|^2/(1+|s|^2) times the unit vector s/|s|, but it avoids a second division. No floating point is used anywhere. The squared norm of a vector whose elements are all zero skips the root and the division altogether and yields a zero vector. While a vector is in flight, `busy` is high and further `start` pulses are dropped. A single-cycle `done` marks the cycle in which `vec_out` first carries the complete result. `vec_out` then holds that result until the next vector completes.

Top module: `capsule_squash`

## Requirements
- R1: With element i at bits [i*W +: W] of the vector, S = sum of s_i^2, m = floor(sqrt(S)), n = floor(S / 2^16) and f = floor(m * 2^16 / (2^16 + n)), output element i equals floor(s_i * f / 2^16). The result is W bits, two's complement, at the same bit position.
- R2: The magnitude used internally is exactly floor(sqrt(S)) of the full-width squared norm.
- R3: An input vector whose elements are all zero gives an all-zero output vector.
- R4: `done` is high for exactly one cycle per accepted vector. `busy` rises in the cycle after an accepted `start` and stays high until `done`, and it is low in the `done` cycle.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The output then belongs to the vector accepted first, and no extra `done` follows.
- R6: `vec_out` keeps its value while `busy` is low and after `done` until another result completes.
- R7: After reset, `busy`, `done` and `vec_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle request to squash the vector on `vec_in` |
| vec_in | input | D*W | Input vector, element i at [i*W +: W], 16 fractional bits |
| busy | output | 1 | A vector is being processed |
| done | output | 1 | One-cycle pulse, `vec_out` is complete |
| vec_out | output | D*W | Squashed vector, same layout and scaling as `vec_in` |

## Verification
A single wrong bit in the root or the quotient register shows at the ports as an output vector whose elements are all off by a common scale. It can be seen only in the `done` cycle, about a hundred cycles after `start`. A wrong accumulator or element index instead skews individual elements. Unit vectors and zero vectors pin the scale factor at known values of one half and zero. A bad sequencer shows up sooner, as `busy` dropping early, `done` lasting two cycles, or a second `done` after an ignored `start`.

// File: rtl/capsule_squash_pkg.sv
package capsule_squash_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ACC,
    SQ_RGO,
    SQ_RWAIT,
    SQ_DGO,
    SQ_DWAIT,
    SQ_SCALE,
    SQ_FIN
  } sq_state_e;
endpackage

// File: rtl/csq_isqrt_nr.sv
module csq_isqrt_nr #(
  parameter int RADW = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [RADW-1:0] radicand,
  output logic            fin,
  output logic [RADW/2-1:0] root
);
  localparam int QW  = RADW / 2;
  localparam int RW  = QW + 3;
  localparam int CW  = $clog2(QW + 1);

  logic [RADW-1:0] rad_q, rad_n;
  logic [RW-1:0]   rem_q, rem_n, shifted;
  logic [QW-1:0]   q_q, q_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            run_q, run_n, fin_q, fin_n;

  always_comb begin
    rad_n   = rad_q;
    rem_n   = rem_q;
    q_n     = q_q;
    cnt_n   = cnt_q;
    run_n   = run_q;
    fin_n   = 1'b0;
    shifted = (rem_q << 2) | RW'(rad_q[RADW-1 -: 2]);
    if (go) begin
      rad_n = radicand;
      rem_n = '0;
      q_n   = '0;
      cnt_n = CW'(QW);
      run_n = 1'b1;
    end else if (run_q) begin
      if (!rem_q[RW-1]) rem_n = shifted - RW'({q_q, 2'b01});
      else              rem_n = shifted + RW'({q_q, 2'b11});
      q_n   = {q_q[QW-2:0], ~rem_n[RW-1]};
      rad_n = rad_q << 2;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rad_q <= rad_n;
      rem_q <= rem_n;
      q_q   <= q_n;
      cnt_q <= cnt_n;
      run_q <= run_n;
      fin_q <= fin_n;
    end
  end

  assign fin  = fin_q;
  assign root = q_q;
endmodule

// File: rtl/csq_divider.sv
module csq_divider #(
  parameter int NW  = 41,
  parameter int DW  = 35,
  parameter int QOW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] numer,
  input  logic [DW-1:0] denom,
  output logic          fin,
  output logic [QOW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]  num_q, num_n;
  logic [DW-1:0]  den_q, den_n, rem_q, rem_n;
  logic [DW:0]    trial;
  logic [QOW-1:0] q_q, q_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           run_q, run_n, fin_q, fin_n;

  always_comb begin
    num_n = num_q;
    den_n = den_q;
    rem_n = rem_q;
    q_n   = q_q;
    cnt_n = cnt_q;
    run_n = run_q;
    fin_n = 1'b0;
    trial = {rem_q, num_q[NW-1]};
    if (go) begin
      num_n = numer;
      den_n = denom;
      rem_n = '0;
      q_n   = '0;
      cnt_n = CW'(NW);
      run_n = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_n = DW'(trial - {1'b0, den_q});
        q_n   = {q_q[QOW-2:0], 1'b1};
      end else begin
        rem_n = DW'(trial);
        q_n   = {q_q[QOW-2:0], 1'b0};
      end
      num_n = num_q << 1;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      num_q <= num_n;
      den_q <= den_n;
      rem_q <= rem_n;
      q_q   <= q_n;
      cnt_q <= cnt_n;
      run_q <= run_n;
      fin_q <= fin_n;
    end
  end

  assign fin = fin_q;
  assign quo = q_q;
endmodule

// File: rtl/capsule_squash.sv
module capsule_squash
  import capsule_squash_pkg::*;
#(
  parameter int W    = 24,
  parameter int D    = 4,
  parameter int FRAC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [D*W-1:0] vec_in,
  output logic           busy,
  output logic           done,
  output logic [D*W-1:0] vec_out
);
  localparam int LOGD = (D > 1) ? $clog2(D) : 1;
  localparam int SQW  = 2 * W + LOGD;
  localparam int RADW = SQW + (SQW % 2);
  localparam int MAGW = RADW / 2;
  localparam int NUMW = MAGW + FRAC;
  localparam int DIVW = RADW - FRAC + 1;
  localparam int FW   = FRAC + 1;
  localparam int PW   = W + FW + 1;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  sq_state_e          state_q, state_n;
  logic [LOGD-1:0]    idx_q, idx_n;
  logic signed [W-1:0] s_q [D];
  logic signed [W-1:0] s_n [D];
  logic [W-1:0]       o_q [D];
  logic [W-1:0]       o_n [D];
  logic [RADW-1:0]    sumsq_q, sumsq_n;
  logic [MAGW-1:0]    mag_q, mag_n;
  logic [FW-1:0]      f_q, f_n;

  logic               root_go, root_fin, div_go, div_fin;
  logic [MAGW-1:0]    root_res;
  logic [FW-1:0]      div_res;
  logic [DIVW-1:0]    div_den;
  logic signed [2*W-1:0] sq_term;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  prod_sh;
  logic               idx_last;

  assign idx_last = (idx_q == LOGD'(D - 1));
  assign sq_term  = s_q[idx_q] * s_q[idx_q];
  assign prod     = PW'(s_q[idx_q]) * $signed({{(PW-FW){1'b0}}, f_q});
  assign prod_sh  = prod >>> FRAC;
  assign div_den  = DIVW'(sumsq_q >> FRAC) + (DIVW'(1) << FRAC);
  assign root_go  = (state_q == SQ_RGO) && (sumsq_q != '0);
  assign div_go   = (state_q == SQ_DGO);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    sumsq_n = sumsq_q;
    mag_n   = mag_q;
    f_n     = f_q;
    for (int i = 0; i < D; i++) begin
      s_n[i] = s_q[i];
      o_n[i] = o_q[i];
    end
    unique case (state_q)
      SQ_IDLE, SQ_FIN: begin
        if (start) begin
          for (int i = 0; i < D; i++) s_n[i] = vec_in[i*W +: W];
          sumsq_n = '0;
          idx_n   = '0;
          state_n = SQ_ACC;
        end else begin
          state_n = SQ_IDLE;
        end
      end
      SQ_ACC: begin
        sumsq_n = sumsq_q + RADW'($unsigned(sq_term));
        if (idx_last) begin
          idx_n   = '0;
          state_n = SQ_RGO;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      SQ_RGO: begin
        if (sumsq_q == '0) begin
          for (int i = 0; i < D; i++) o_n[i] = '0;
          state_n = SQ_FIN;
        end else begin
          state_n = SQ_RWAIT;
        end
      end
      SQ_RWAIT: begin
        if (root_fin) begin
          mag_n   = root_res;
          state_n = SQ_DGO;
        end
      end
      SQ_DGO: state_n = SQ_DWAIT;
      SQ_DWAIT: begin
        if (div_fin) begin
          f_n     = div_res;
          idx_n   = '0;
          state_n = SQ_SCALE;
        end
      end
      SQ_SCALE: begin
        o_n[idx_q] = prod_sh[W-1:0];
        if (idx_last) state_n = SQ_FIN;
        else          idx_n   = idx_q + 1'b1;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      sumsq_q <= '0;
      mag_q   <= '0;
      f_q     <= '0;
      for (int i = 0; i < D; i++) begin
        s_q[i] <= '0;
        o_q[i] <= '0;
      end
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      sumsq_q <= sumsq_n;
      mag_q   <= mag_n;
      f_q     <= f_n;
      for (int i = 0; i < D; i++) begin
        s_q[i] <= s_n[i];
        o_q[i] <= o_n[i];
      end
    end
  end

  csq_isqrt_nr #(.RADW(RADW)) u_root (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .go       (root_go),
    .radicand (sumsq_q),
    .fin      (root_fin),
    .root     (root_res)
  );

  csq_divider #(.NW(NUMW), .DW(DIVW), .QOW(FW)) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .go    (div_go),
    .numer ({mag_q, {FRAC{1'b0}}}),
    .denom (div_den),
    .fin   (div_fin),
    .quo   (div_res)
  );

  genvar g;
  generate
    for (g = 0; g < D; g++) begin : g_out
      assign vec_out[g*W +: W] = o_q[g];
    end
  endgenerate

  assign done = (state_q == SQ_FIN);
  assign busy = (state_q != SQ_IDLE) && (state_q != SQ_FIN);
endmodule

// File: rtl/capsule_squash_checker.sv
module capsule_squash_checker #(
  parameter int W    = 24,
  parameter int D    = 4,
  parameter int RADW = 50
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [D*W-1:0]  vec_out,
  input logic [RADW-1:0] sumsq,
  input logic            root_fin,
  input logic [RADW/2-1:0] root_res
);
  localparam int XW = RADW + 4;

  logic [XW-1:0] r_lo, r_hi;
  assign r_lo = XW'(root_res) * XW'(root_res);
  assign r_hi = (XW'(root_res) + 1'b1) * (XW'(root_res) + 1'b1);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(vec_out));

  assert_zero_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sumsq == '0) |-> (vec_out == '0));

  assert_root_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    root_fin |-> (r_lo <= XW'(sumsq)) && (r_hi > XW'(sumsq)));
endmodule

bind capsule_squash capsule_squash_checker #(.W(W), .D(D), .RADW(RADW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .vec_out  (vec_out),
  .sumsq    (sumsq_q),
  .root_fin (root_fin),
  .root_res (root_res)
);

// File: tb/capsule_squash_bench.sv
module capsule_squash_bench;
  localparam int W = 24;
  localparam int D = 4;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [D*W-1:0] vec_in;
  logic           busy;
  logic           done;
  logic [D*W-1:0] vec_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  capsule_squash #(.W(W), .D(D), .FRAC(16)) u_capsule_squash (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in),
    .busy(busy), .done(done), .vec_out(vec_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint s);
    longint r = 0;
    for (int b = 26; b >= 0; b--) begin
      longint c = r | (longint'(1) << b);
      if (c * c <= s) r = c;
    end
    return r;
  endfunction

  // R1 reference model
  function automatic logic [D*W-1:0] squash_ref(input logic [D*W-1:0] v);
    longint s, m, n, f, e;
    logic [D*W-1:0] res;
    s = 0;
    for (int i = 0; i < D; i++) begin
      e = longint'($signed(v[i*W +: W]));
      s += e * e;
    end
    m = isqrt(s);
    n = s >>> 16;
    f = (m << 16) / (65536 + n);
    for (int i = 0; i < D; i++) begin
      e = longint'($signed(v[i*W +: W]));
      e = (e * f) >>> 16;
      res[i*W +: W] = e[W-1:0];
    end
    return res;
  endfunction

  task automatic run_vec(input logic [D*W-1:0] v, input bit inject, input logic [D*W-1:0] other, input string tag);
    logic [D*W-1:0] exp;
    logic [D*W-1:0] held;
    int waited = 0;
    int extra_done = 0;
    exp = squash_ref(v);
    @(negedge clk);
    vec_in = v;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    check(busy == 1'b1, "R4 busy after start", longint'(busy), 1);
    while (!done && waited < 3000) begin
      if (inject && waited == 3) begin
        vec_in = other;
        start  = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
      if (!done && !busy) begin
        check(1'b0, "R4 busy dropped before done", 0, 1);
        break;
      end
    end
    start = 1'b0;
    check(done == 1'b1, "R4 done seen", longint'(done), 1);
    check(busy == 1'b0, "R4 busy low with done", longint'(busy), 0);
    for (int i = 0; i < D; i++)
      check(vec_out[i*W +: W] == exp[i*W +: W], {"R1 element ", tag},
            longint'($signed(vec_out[i*W +: W])), longint'($signed(exp[i*W +: W])));
    held = vec_out;
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", longint'(done), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) extra_done++;
    end
    check(extra_done == 0, "R5 no second done", extra_done, 0);
    check(vec_out == held, "R6 output held", longint'(vec_out[W-1:0]), longint'(held[W-1:0]));
  endtask

  function automatic logic [D*W-1:0] mk(input int a, input int b, input int c, input int d);
    logic [D*W-1:0] r;
    r[0*W +: W] = a[W-1:0];
    r[1*W +: W] = b[W-1:0];
    r[2*W +: W] = c[W-1:0];
    r[3*W +: W] = d[W-1:0];
    return r;
  endfunction

  initial begin
    logic [D*W-1:0] v;
    int seed_dummy;
    seed_dummy = $urandom(1234);
    rst_n  = 1'b0;
    start  = 1'b0;
    vec_in = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(busy == 1'b0, "R7 busy reset", longint'(busy), 0);
    check(done == 1'b0, "R7 done reset", longint'(done), 0);
    check(vec_out == '0, "R7 vec_out reset", longint'(vec_out[W-1:0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: unit vector along element 0 gives 0.5
    run_vec(mk(65536, 0, 0, 0), 1'b0, '0, "unit");
    check($signed(vec_out[0 +: W]) == 32768, "R1 unit scale half",
          longint'($signed(vec_out[0 +: W])), 32768);
    // R1: negative unit
    run_vec(mk(0, 0, -65536, 0), 1'b0, '0, "neg unit");
    // R3: zero vector after a nonzero one
    run_vec(mk(0, 0, 0, 0), 1'b0, '0, "zero");
    check(vec_out == '0, "R3 zero output", longint'(vec_out[W-1:0]), 0);
    // R1: extremes
    run_vec(mk(-8388608, 8388607, -8388608, 8388607), 1'b0, '0, "extreme");
    run_vec(mk(1, -1, 0, 1), 1'b0, '0, "tiny");
    // R5: start during busy ignored
    run_vec(mk(30000, -40000, 12345, 5), 1'b1, mk(65536, 65536, 0, 0), "R5 ignore");

    // R1/R2 random vectors, mixed ranges
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < D; i++) begin
        int e;
        if (t % 2 == 0) e = int'($urandom_range(0, 262143)) - 131072;
        else            e = int'($urandom);
        v[i*W +: W] = e[W-1:0];
      end
      run_vec(v, (t % 7) == 3, mk(1, 2, 3, 4), "R2 random");
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule